// File: doc/BRIEF.md
# Power-up strap latch and clock mode controller

This block sits beside a clock generator and owns a pin that has two jobs. Right after power-on reset the pin is only an input. Its level, together with a dedicated select input, is tracked into a two-bit strap latch while a power-on timer counts reference clock cycles. When the timer reaches its terminal count, the latch freezes and the pin's output driver is allowed on. From then on the pin carries a clock.

The frozen straps and a live active-low three-state control pick one of three modes. In high-impedance mode every output is floated. In test mode the block itself derives every clock output from the incoming test clock through fixed dividers: divide by 2, 4, 6 or 12, plus a straight pass-through. In normal mode it only drives per-output enables and registered frequency-select codes for the PLLs.

Every generated clock stays low until it is enabled. The dividers restart together, low and phase-aligned, each time test mode is entered. This avoids a short first pulse.

Top module: `strap_mode_ctrl`

## Requirements
- R1: After reset is released, `pin_oe_o` and every bit of `clk_en_o` stay 0 for the first TIMER_CYCLES rising clock edges. `pin_oe_o` becomes 1 at edge TIMER_CYCLES when the mode is not high-impedance.
- R2: The strap pair {strap1 = `pin_i`, strap0 = `sel0_i`} follows the inputs up to and including edge TIMER_CYCLES. After that it is frozen until the next reset, so later changes of `pin_i` or `sel0_i` alter neither `mode_o` nor the codes.
- R3: Mode decode on `mode_o`: 2 (normal) when `tri_n_i`=1; 1 (test) when `tri_n_i`=0 and straps are 01; 0 (high-impedance) when `tri_n_i`=0 and straps are any other value. `hiz_o` is 1 exactly in mode 0, and `pin_oe_o` is 0 in mode 0.
- R4: In normal mode, all bits of `clk_en_o` become 1 one edge after `pin_oe_o` rises. They go to 0 one edge after the mode leaves normal.
- R5: `cpu_code_o` (0=66 MHz, 1=100 MHz, 2=133 MHz) is loaded only on the rising edge of the enables. Straps 00 give 0, 01 give 1, 10 give 2 and 11 give 2. `sdram_code_o` (0=100 MHz, 1=133 MHz) is loaded at the same moment and is 1 only for straps 10.
- R6: In test mode, `tclk_o` bit order is {ref, apic, pci, usb48, v66, sdram, cpu} from bit 6 down to bit 0. Let j be the number of edges since the first running edge. Bit g (g<6), with ratio r = 4,4,6,2,12,12 for g = 0..5, equals ((j mod r) >= r/2).
- R7: Divided outputs `tclk_o[5:0]` are 0 whenever test mode is not running. They restart from j=0 on every re-entry into test mode.
- R8: In test mode `tclk_o[6]` passes the clock through undivided; it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference / test clock |
| rst_ni | input | 1 | Active-low power-on reset |
| tri_n_i | input | 1 | Active-low three-state control (live) |
| sel0_i | input | 1 | Dedicated select strap input |
| pin_i | input | 1 | Level seen on the shared pin while it is an input |
| pin_oe_o | output | 1 | Output driver enable of the shared pin |
| hiz_o | output | 1 | All clock outputs high-impedance |
| mode_o | output | 2 | Decoded mode: 0 hiz, 1 test, 2 normal |
| clk_en_o | output | 7 | Per-output enables for normal mode |
| cpu_code_o | output | 2 | CPU frequency-select code |
| sdram_code_o | output | 1 | SDRAM frequency-select code |
| tclk_o | output | 7 | Test-mode clocks, bit order per R6 |

## Verification
Power-ups are run with every combination of the three-state control and the two straps, both directed and drawn at random. This separates the three decode branches and all four code mappings. The edge just before and the edge at the timer expiry show whether the handover is off by one. Flipping the strap inputs after expiry shows whether the latch is truly frozen. In test mode each divided output is compared cycle by cycle over two full 12-cycle spans. A leave-and-re-enter sequence then shows whether the dividers restart low and aligned, rather than resuming mid-count.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        MODE_HIZ    = 2'd0,
        MODE_TEST   = 2'd1,
        MODE_NORMAL = 2'd2
    } mode_e;

    localparam int unsigned OUT_CPU   = 0;
    localparam int unsigned OUT_SDRAM = 1;
    localparam int unsigned OUT_V66   = 2;
    localparam int unsigned OUT_USB   = 3;
    localparam int unsigned OUT_PCI   = 4;
    localparam int unsigned OUT_APIC  = 5;
    localparam int unsigned OUT_REF   = 6;
    localparam int unsigned NUM_OUTS  = 7;
    localparam int unsigned NUM_DIVS  = NUM_OUTS - 1;

    // divide ratio per divided output, index = output bit
    localparam int unsigned DIV_RATIO [NUM_DIVS] = '{4, 4, 6, 2, 12, 12};

    function automatic mode_e decode_mode(input logic tri_n, input logic [1:0] strap);
        if (tri_n)               return MODE_NORMAL;
        else if (strap == 2'b01) return MODE_TEST;
        else                     return MODE_HIZ;
    endfunction

    function automatic logic [1:0] cpu_code_of(input logic [1:0] strap);
        case (strap)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic sdram_code_of(input logic [1:0] strap);
        return strap == 2'b10;
    endfunction

endpackage

// File: rtl/smc_por_timer.sv
module smc_por_timer #(
    parameter int unsigned TIMER_CYCLES = 28636
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic done_o
);
    localparam int unsigned CW = $clog2(TIMER_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.done = (st_q.cnt == CW'(TIMER_CYCLES - 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R1
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.done |-> (32'(st_q.cnt) < TIMER_CYCLES));

    // R1
    done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> st_q.done);

endmodule

// File: rtl/smc_test_div.sv
module smc_test_div import smc_pkg::*; #(
    parameter int unsigned SPAN = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    output logic [NUM_OUTS-1:0] tclk_o
);
    localparam int unsigned CW = $clog2(SPAN);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_i;
        if (st_q.run && run_i)
            st_d.cnt = (st_q.cnt == CW'(SPAN - 1)) ? '0 : st_q.cnt + 1'b1;
        else
            st_d.cnt = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_DIVS; g++) begin : g_div
        assign tclk_o[g] = st_q.run &&
                           ((32'(st_q.cnt) % DIV_RATIO[g]) >= (DIV_RATIO[g] / 2));
    end

    assign tclk_o[OUT_REF] = clk_i & st_q.run;

    // R7
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.run) |-> (tclk_o[NUM_DIVS-1:0] == '0));

    // R6
    half_rate_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.run && $past(st_q.run)) |-> (tclk_o[OUT_USB] != $past(tclk_o[OUT_USB])));

    // R7
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.run) |-> (tclk_o[NUM_DIVS-1:0] == '0));

endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl import smc_pkg::*; #(
    parameter int unsigned TIMER_CYCLES = 28636,
    parameter int unsigned DIV_SPAN     = 12
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tri_n_i,
    input  logic                sel0_i,
    input  logic                pin_i,
    output logic                pin_oe_o,
    output logic                hiz_o,
    output logic [1:0]          mode_o,
    output logic [NUM_OUTS-1:0] clk_en_o,
    output logic [1:0]          cpu_code_o,
    output logic                sdram_code_o,
    output logic [NUM_OUTS-1:0] tclk_o
);
    typedef struct packed {
        logic [1:0] strap;
        logic       en;
        logic [1:0] cpu;
        logic       sdram;
    } ctl_t;

    ctl_t  st_d, st_q;
    logic  timer_done;
    mode_e mode;

    smc_por_timer #(.TIMER_CYCLES(TIMER_CYCLES)) timer_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .done_o (timer_done)
    );

    assign mode = decode_mode(tri_n_i, st_q.strap);

    always_comb begin
        st_d = st_q;
        if (!timer_done)
            st_d.strap = {pin_i, sel0_i};
        st_d.en = timer_done && (mode == MODE_NORMAL);
        if (st_d.en && !st_q.en) begin
            st_d.cpu   = cpu_code_of(st_q.strap);
            st_d.sdram = sdram_code_of(st_q.strap);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    smc_test_div #(.SPAN(DIV_SPAN)) div_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (timer_done && (mode == MODE_TEST)),
        .tclk_o (tclk_o)
    );

    assign pin_oe_o     = timer_done && (mode != MODE_HIZ);
    assign hiz_o        = (mode == MODE_HIZ);
    assign mode_o       = mode;
    assign clk_en_o     = {NUM_OUTS{st_q.en}};
    assign cpu_code_o   = st_q.cpu;
    assign sdram_code_o = st_q.sdram;

    // R1
    no_early_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !timer_done |-> (!pin_oe_o && (clk_en_o == '0)));

    // R2
    strap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timer_done && $past(timer_done)) |-> $stable(st_q.strap));

    // R5
    code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.en && $past(st_q.en)) |-> ($stable(cpu_code_o) && $stable(sdram_code_o)));

    // R3
    hiz_no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hiz_o |=> (clk_en_o == '0));

    // R3
    hiz_no_test_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hiz_o && $past(hiz_o)) |-> (tclk_o == '0));

endmodule

// File: tb/strap_mode_ctrl_tb_top.sv
module strap_mode_ctrl_tb_top;
    localparam int unsigned TC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tri_n = 1'b1;
    logic       sel0 = 1'b0;
    logic       pin = 1'b0;
    logic       pin_oe, hiz, sdram_code;
    logic [1:0] mode, cpu_code;
    logic [6:0] clk_en, tclk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    strap_mode_ctrl #(.TIMER_CYCLES(TC), .DIV_SPAN(12)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tri_n_i(tri_n), .sel0_i(sel0), .pin_i(pin),
        .pin_oe_o(pin_oe), .hiz_o(hiz), .mode_o(mode), .clk_en_o(clk_en),
        .cpu_code_o(cpu_code), .sdram_code_o(sdram_code), .tclk_o(tclk)
    );

    function automatic int exp_mode(input bit t, input bit s1, input bit s0);
        if (t) return 2;
        if (!s1 && s0) return 1;
        return 0;
    endfunction

    function automatic int exp_cpu(input bit s1, input bit s0);
        if (s1) return 2;
        return s0 ? 1 : 0;
    endfunction

    function automatic int exp_sdram(input bit s1, input bit s0);
        return (s1 && !s0) ? 1 : 0;
    endfunction

    function automatic logic [6:0] exp_tclk(input int j);
        int r [6] = '{4, 4, 6, 2, 12, 12};
        logic [6:0] v;
        for (int g = 0; g < 6; g++) v[g] = ((j % r[g]) >= r[g] / 2);
        v[6] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic power_up(input bit t, input bit s1, input bit s0);
        int m;
        @(negedge clk);
        rst_n = 1'b0;
        tri_n = t; pin = s1; sel0 = s0;
        @(negedge clk);
        check(pin_oe == 0 && clk_en == 0 && tclk == 0, "R1 reset state",
              int'({pin_oe, clk_en, tclk}), 0);
        rst_n = 1'b1;
        m = exp_mode(t, s1, s0);
        for (int k = 1; k < int'(TC); k++) step();
        check(pin_oe == 0, "R1 before expiry oe", int'(pin_oe), 0);
        check(clk_en == 0, "R1 before expiry en", int'(clk_en), 0);
        step();
        check(pin_oe == (m != 0), "R1 oe at expiry", int'(pin_oe), int'(m != 0));
        check(int'(mode) == m, "R3 mode", int'(mode), m);
        check(hiz == (m == 0), "R3 hiz", int'(hiz), int'(m == 0));
        step();
        check(clk_en == ((m == 2) ? 7'h7f : 7'h00), "R4 enables",
              int'(clk_en), (m == 2) ? 127 : 0);
        if (m == 2) begin
            check(int'(cpu_code) == exp_cpu(s1, s0), "R5 cpu code",
                  int'(cpu_code), exp_cpu(s1, s0));
            check(int'(sdram_code) == exp_sdram(s1, s0), "R5 sdram code",
                  int'(sdram_code), exp_sdram(s1, s0));
        end
        if (m == 1) begin
            for (int j = 0; j < 24; j++) begin
                check(tclk == exp_tclk(j), "R6 R8 test clocks", int'(tclk), int'(exp_tclk(j)));
                step();
            end
        end else begin
            check(tclk == 0, "R7 R8 no test clocks", int'(tclk), 0);
        end
        @(negedge clk);
        pin = ~s1; sel0 = ~s0;
        repeat (3) step();
        check(int'(mode) == m, "R2 frozen mode", int'(mode), m);
        if (m == 2)
            check(int'(cpu_code) == exp_cpu(s1, s0) && int'(sdram_code) == exp_sdram(s1, s0),
                  "R2 frozen codes", int'({cpu_code, sdram_code}),
                  (exp_cpu(s1, s0) << 1) | exp_sdram(s1, s0));
    endtask

    initial begin
        void'($urandom(32'd4242));
        // directed: every mode and code mapping
        power_up(1'b1, 1'b0, 1'b0);
        power_up(1'b1, 1'b0, 1'b1);
        power_up(1'b1, 1'b1, 1'b0);
        power_up(1'b1, 1'b1, 1'b1);
        power_up(1'b0, 1'b0, 1'b0);
        power_up(1'b0, 1'b1, 1'b1);
        power_up(1'b0, 1'b0, 1'b1);
        // directed: leave test mode and re-enter (R7, R4)
        @(negedge clk);
        tri_n = 1'b1;
        step();
        check(tclk[5:0] == 0, "R7 low after leaving test", int'(tclk), 0);
        check(clk_en == 7'h7f, "R4 enable on entering normal", int'(clk_en), 127);
        check(int'(cpu_code) == 1, "R5 code on late enable", int'(cpu_code), 1);
        @(negedge clk);
        tri_n = 1'b0;
        step();
        check(clk_en == 0, "R4 enable drops", int'(clk_en), 0);
        for (int j = 0; j < 13; j++) begin
            check(tclk == exp_tclk(j), "R7 aligned restart", int'(tclk), int'(exp_tclk(j)));
            step();
        end
        // random power-ups
        for (int i = 0; i < 16; i++) begin
            logic [2:0] r;
            r = 3'($urandom);
            power_up(r[2], r[1], r[0]);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule